// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide, I/O-mapped register bank for a single-processor board. A bus master presents a port address with a read or write strobe, and the bank answers the ports it owns. Some ports return fixed identification, feature and equipment bytes. Some hold control bits that leave the block as level outputs: a soft-reset request, a little-endian byte-order flag, a disk activity lamp, a 4-bit system control field and an I/O map type select. Two ports do not store data. A write to either one raises a one-cycle pulse that asks an external non-volatile memory to toggle one of its two password-protect levels. A pair of plain scratch bytes sits at a separate port pair.

The bank claims three port regions: the single special port 0x0092, the window 0x0800 to 0x0851, and the scratch pair 0x0398 to 0x0399. A registered claim flag tells the bus which accesses the bank took. A write to a port inside the window that has no write function raises a one-cycle error flag and changes nothing. All outputs are registered. Read data and the claim flag appear in the cycle after the strobe. Control outputs and pulses change on the clock edge that samples the write.

Top module: `sysctl_regbank`

## Requirements
- R1: While reset is high, and in the first cycle after it, reset_req, le_mode, disk_led, sys_ctl, io_map_sel, both unlock pulses, bad_wr, hit and rd_data are all zero.
- R2: A write to port 0x0092 sets reset_req to data bit 0 and le_mode to data bit 1. A read of 0x0092 returns 0x00. No other access changes either output.
- R3: Reads of 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these three ports change no output and raise no error.
- R4: Reads of 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to 0x0808 sets disk_led to data bit 0. A read of 0x0808 returns 0xFF.
- R6: A write to 0x0810 drives unlock1_pulse high for exactly the cycle after the write. A write to 0x0812 does the same on unlock2_pulse. No data is stored, and neither pulse rises for any other access.
- R7: A write to 0x081C stores data bits 3:0 in sys_ctl. A read of 0x081C returns sys_ctl with bits 7:4 zero.
- R8: A write to 0x0850 stores data bit 0 in io_map_sel. A read returns it in bit 0 with the other bits zero.
- R9: A read of any other port in 0x0800 to 0x0851 returns 0xFF. This includes 0x0812 and 0x0814. A write to 0x0814 is ignored without error.
- R10: Ports 0x0398 and 0x0399 are two independent read/write bytes. A read returns the last value written to the same port.
- R11: hit is high in the cycle after a read or write to a claimed port (0x0092, 0x0398 to 0x0399, or 0x0800 to 0x0851) and low otherwise. rd_data is 0x00 in every cycle that does not follow a read of a claimed port.
- R12: A write to a port in 0x0800 to 0x0851 that has no write function raises bad_wr for the cycle after the write and changes no output. The affected ports are 0x080C, 0x0818, 0x0823 and all ports not named above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 16 | I/O port address |
| rd_en | input | 1 | Byte read strobe |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle after rd_en |
| hit | output | 1 | The bank claimed the previous cycle's access |
| reset_req | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity lamp |
| sys_ctl | output | 4 | System control field |
| io_map_sel | output | 1 | I/O map type select |
| unlock1_pulse | output | 1 | One-cycle toggle request for protect level 1 |
| unlock2_pulse | output | 1 | One-cycle toggle request for protect level 2 |
| bad_wr | output | 1 | One-cycle flag for a write to an in-window port with no write function |

## Verification
The bench aims at ports whose read and write meanings differ.

- Port 0x0810 reads a constant but pulses on a write. A design that merges the two would store data there or fail to pulse.
- Port 0x0812 must read 0xFF.
- A decoder that treated 0x0814 as undecoded would flag a harmless write as an error.
- A decoder that skipped the error for 0x080C, 0x0818 or 0x0823 would stay silent on a bad write.

Further cases cover the window edges and back-to-back writes:

- Addresses 0x0851 and 0x0852, and 0x0397 and 0x039A next to the scratch pair, catch off-by-one range compares. These show up as a wrong hit or as 0xFF against 0x00.
- Back-to-back writes to the special port check that reset_req and le_mode follow each write.
- High data bits written to 0x081C and 0x0850 catch a field that keeps bits it should drop.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int P_SPECIAL = 'h0092;
  localparam int P_ID_CPU  = 'h0800;
  localparam int P_ID_FEAT = 'h0802;
  localparam int P_ID_STAT = 'h0803;
  localparam int P_LED     = 'h0808;
  localparam int P_EQUIP   = 'h080C;
  localparam int P_LOCK1   = 'h0810;
  localparam int P_LOCK2   = 'h0812;
  localparam int P_CACHE   = 'h0814;
  localparam int P_KEY     = 'h0818;
  localparam int P_SYSCTL  = 'h081C;
  localparam int P_L2      = 'h0823;
  localparam int P_MAP     = 'h0850;
  localparam int P_WIN_LO  = 'h0800;
  localparam int P_WIN_HI  = 'h0851;

  localparam int C_ID_CPU  = 'hEF;
  localparam int C_ID_FEAT = 'hAD;
  localparam int C_ID_STAT = 'hE0;
  localparam int C_EQUIP   = 'h3C;
  localparam int C_EXTFEAT = 'h39;
  localparam int C_KEY     = 'h00;
  localparam int C_L2      = 'h03;
  localparam int C_UNUSED  = 'hFF;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SPECIAL,
    SEL_ID_CPU,
    SEL_ID_FEAT,
    SEL_ID_STAT,
    SEL_LED,
    SEL_EQUIP,
    SEL_LOCK1,
    SEL_LOCK2,
    SEL_CACHE,
    SEL_KEY,
    SEL_SYSCTL,
    SEL_L2,
    SEL_MAP,
    SEL_SCRATCH,
    SEL_OTHER
  } port_sel_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int SCRATCH_BASE = 'h0398,
  parameter int SCRATCH_N    = 2,
  localparam int IDX_W       = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic [ADDR_W-1:0] port_addr,
  output port_sel_e         sel,
  output logic [IDX_W-1:0]  scr_idx,
  output logic              claimed
);

  localparam logic [ADDR_W-1:0] SCR_LO = ADDR_W'(SCRATCH_BASE);
  localparam logic [ADDR_W-1:0] SCR_HI = ADDR_W'(SCRATCH_BASE + SCRATCH_N - 1);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(P_WIN_LO);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(P_WIN_HI);

  logic [ADDR_W-1:0] scr_off;
  assign scr_off = port_addr - SCR_LO;

  always_comb begin
    sel     = SEL_NONE;
    scr_idx = '0;
    if (port_addr >= SCR_LO && port_addr <= SCR_HI) begin
      sel     = SEL_SCRATCH;
      scr_idx = scr_off[IDX_W-1:0];
    end else if (port_addr == ADDR_W'(P_SPECIAL)) begin
      sel = SEL_SPECIAL;
    end else if (port_addr >= WIN_LO && port_addr <= WIN_HI) begin
      case (port_addr)
        ADDR_W'(P_ID_CPU):  sel = SEL_ID_CPU;
        ADDR_W'(P_ID_FEAT): sel = SEL_ID_FEAT;
        ADDR_W'(P_ID_STAT): sel = SEL_ID_STAT;
        ADDR_W'(P_LED):     sel = SEL_LED;
        ADDR_W'(P_EQUIP):   sel = SEL_EQUIP;
        ADDR_W'(P_LOCK1):   sel = SEL_LOCK1;
        ADDR_W'(P_LOCK2):   sel = SEL_LOCK2;
        ADDR_W'(P_CACHE):   sel = SEL_CACHE;
        ADDR_W'(P_KEY):     sel = SEL_KEY;
        ADDR_W'(P_SYSCTL):  sel = SEL_SYSCTL;
        ADDR_W'(P_L2):      sel = SEL_L2;
        ADDR_W'(P_MAP):     sel = SEL_MAP;
        default:            sel = SEL_OTHER;
      endcase
    end
  end

  assign claimed = (sel != SEL_NONE);

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYSCTL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  port_sel_e           sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic                reset_req,
  output logic                le_mode,
  output logic                disk_led,
  output logic [SYSCTL_W-1:0] sys_ctl,
  output logic                io_map_sel,
  output logic                unlock1_pulse,
  output logic                unlock2_pulse,
  output logic                bad_wr
);

  logic wr_bad_port;
  always_comb begin
    case (sel)
      SEL_EQUIP, SEL_KEY, SEL_L2, SEL_OTHER: wr_bad_port = 1'b1;
      default:                               wr_bad_port = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req     <= 1'b0;
      le_mode       <= 1'b0;
      disk_led      <= 1'b0;
      sys_ctl       <= '0;
      io_map_sel    <= 1'b0;
      unlock1_pulse <= 1'b0;
      unlock2_pulse <= 1'b0;
      bad_wr        <= 1'b0;
    end else begin
      unlock1_pulse <= wr_stb && (sel == SEL_LOCK1);
      unlock2_pulse <= wr_stb && (sel == SEL_LOCK2);
      bad_wr        <= wr_stb && wr_bad_port;
      if (wr_stb) begin
        case (sel)
          SEL_SPECIAL: begin
            reset_req <= wdata[0];
            le_mode   <= wdata[1];
          end
          SEL_LED:    disk_led   <= wdata[0];
          SEL_SYSCTL: sys_ctl    <= wdata[SYSCTL_W-1:0];
          SEL_MAP:    io_map_sel <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  AST_RSTREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && sel == SEL_SPECIAL) |=> $stable(reset_req) && $stable(le_mode)); // R2
  AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (rst)
    unlock1_pulse |-> $past(wr_stb && sel == SEL_LOCK1)); // R6
  AST_LOCK2_CAUSE: assert property (@(posedge clk) disable iff (rst)
    unlock2_pulse |-> $past(wr_stb && sel == SEL_LOCK2)); // R6
  AST_BADWR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bad_wr |-> $past(wr_stb) && $stable(sys_ctl) && $stable(disk_led) && $stable(io_map_sel)); // R12
  AST_SYSCTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && sel == SEL_SYSCTL) |=> $stable(sys_ctl)); // R7

endmodule

// File: rtl/sysctl_scratch.sv
module sysctl_scratch #(
  parameter int DATA_W    = 8,
  parameter int SCRATCH_N = 2,
  localparam int IDX_W    = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [SCRATCH_N];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int SYSCTL_W     = 4,
  parameter int SCRATCH_BASE = 'h0398,
  parameter int SCRATCH_N    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   port_addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                hit,
  output logic                reset_req,
  output logic                le_mode,
  output logic                disk_led,
  output logic [SYSCTL_W-1:0] sys_ctl,
  output logic                io_map_sel,
  output logic                unlock1_pulse,
  output logic                unlock2_pulse,
  output logic                bad_wr
);

  localparam int IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;

  port_sel_e         sel;
  logic [IDX_W-1:0]  scr_idx;
  logic              claimed;
  logic [DATA_W-1:0] scr_rdata;
  logic [DATA_W-1:0] rd_next;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .SCRATCH_BASE(SCRATCH_BASE), .SCRATCH_N(SCRATCH_N)
  ) u_decode (
    .port_addr(port_addr), .sel(sel), .scr_idx(scr_idx), .claimed(claimed)
  );

  sysctl_ctrl #(.DATA_W(DATA_W), .SYSCTL_W(SYSCTL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_en), .sel(sel), .wdata(wr_data),
    .reset_req(reset_req), .le_mode(le_mode), .disk_led(disk_led),
    .sys_ctl(sys_ctl), .io_map_sel(io_map_sel),
    .unlock1_pulse(unlock1_pulse), .unlock2_pulse(unlock2_pulse),
    .bad_wr(bad_wr)
  );

  sysctl_scratch #(.DATA_W(DATA_W), .SCRATCH_N(SCRATCH_N)) u_scratch (
    .clk(clk), .we(wr_en && sel == SEL_SCRATCH), .idx(scr_idx),
    .wdata(wr_data), .rdata(scr_rdata)
  );

  always_comb begin
    case (sel)
      SEL_SPECIAL: rd_next = '0;
      SEL_ID_CPU:  rd_next = DATA_W'(C_ID_CPU);
      SEL_ID_FEAT: rd_next = DATA_W'(C_ID_FEAT);
      SEL_ID_STAT: rd_next = DATA_W'(C_ID_STAT);
      SEL_EQUIP:   rd_next = DATA_W'(C_EQUIP);
      SEL_LOCK1:   rd_next = DATA_W'(C_EXTFEAT);
      SEL_KEY:     rd_next = DATA_W'(C_KEY);
      SEL_L2:      rd_next = DATA_W'(C_L2);
      SEL_SYSCTL:  rd_next = DATA_W'(sys_ctl);
      SEL_MAP:     rd_next = DATA_W'(io_map_sel);
      SEL_SCRATCH: rd_next = scr_rdata;
      SEL_NONE:    rd_next = '0;
      default:     rd_next = DATA_W'(C_UNUSED);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hit     <= 1'b0;
    end else begin
      rd_data <= (rd_en && claimed) ? rd_next : '0;
      hit     <= (rd_en || wr_en) && claimed;
    end
  end

  AST_HIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(rd_en || wr_en)); // R11
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0)); // R11

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        hit, reset_req, le_mode, disk_led, io_map_sel;
  logic [3:0]  sys_ctl;
  logic        unlock1_pulse, unlock2_pulse, bad_wr;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sysctl_regbank u_dut (
    .clk(clk), .rst(rst), .port_addr(port_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .hit(hit), .reset_req(reset_req),
    .le_mode(le_mode), .disk_led(disk_led), .sys_ctl(sys_ctl),
    .io_map_sel(io_map_sel), .unlock1_pulse(unlock1_pulse),
    .unlock2_pulse(unlock2_pulse), .bad_wr(bad_wr)
  );

  bit       m_rq, m_le, m_led, m_map;
  bit [3:0] m_sc;
  bit [7:0] m_scr [2];

  function automatic bit in_win(input logic [15:0] a);
    return a >= 16'h0800 && a <= 16'h0851;
  endfunction

  function automatic bit claimed_m(input logic [15:0] a);
    return in_win(a) || a == 16'h0092 || a == 16'h0398 || a == 16'h0399;
  endfunction

  function automatic bit bad_m(input logic [15:0] a);
    if (!in_win(a)) return 1'b0;
    case (a)
      16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
      16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] rd_m(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_sc};
      16'h0850: return {7'h0, m_map};
      16'h0398: return m_scr[0];
      16'h0399: return m_scr[1];
      default:  return in_win(a) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic string tag_m(input logic [15:0] a, input bit w);
    if (a == 16'h0092) return "R2";
    if (a == 16'h0800 || a == 16'h0802 || a == 16'h0803) return "R3";
    if (!w && (a == 16'h080C || a == 16'h0810 || a == 16'h0818 || a == 16'h0823)) return "R4";
    if (a == 16'h0808 && w) return "R5";
    if (w && (a == 16'h0810 || a == 16'h0812)) return "R6";
    if (a == 16'h081C) return "R7";
    if (a == 16'h0850) return "R8";
    if (a == 16'h0398 || a == 16'h0399) return "R10";
    if (w && bad_m(a)) return "R12";
    if (in_win(a)) return "R9";
    return "R11";
  endfunction

  task automatic check_all(input string req, input logic [7:0] erd, input bit ehit,
                           input bit ep1, input bit ep2, input bit ebad);
    logic [19:0] act, exp;
    act = {rd_data, hit, reset_req, le_mode, disk_led, sys_ctl, io_map_sel,
           unlock1_pulse, unlock2_pulse, bad_wr};
    exp = {erd, ehit, m_rq, m_le, m_led, m_sc, m_map, ep1, ep2, ebad};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, port_addr, act, exp);
    end
  endtask

  task automatic op(input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a; wr_data = d; wr_en = w; rd_en = !w;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (w) begin
      case (a)
        16'h0092: begin m_rq = d[0]; m_le = d[1]; end
        16'h0808: m_led = d[0];
        16'h081C: m_sc = d[3:0];
        16'h0850: m_map = d[0];
        16'h0398: m_scr[0] = d;
        16'h0399: m_scr[1] = d;
        default: ;
      endcase
      check_all(tag_m(a, 1'b1), 8'h00, claimed_m(a), a == 16'h0810,
                a == 16'h0812, bad_m(a));
    end else begin
      check_all(tag_m(a, 1'b0), rd_m(a), claimed_m(a), 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check_all(req, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic model_reset;
    m_rq = 0; m_le = 0; m_led = 0; m_map = 0; m_sc = 0;
  endtask

  localparam logic [15:0] PORTS [20] = '{16'h0092, 16'h0800, 16'h0802, 16'h0803,
    16'h0808, 16'h080C, 16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C,
    16'h0823, 16'h0850, 16'h0851, 16'h0852, 16'h07FF, 16'h0397, 16'h039A,
    16'h0398, 16'h0399};

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    idle_check("R1");

    op(1, 16'h0398, 8'h5C); op(1, 16'h0399, 8'hA3);
    op(0, 16'h0398, 8'h00); op(0, 16'h0399, 8'h00);     // R10
    op(1, 16'h0092, 8'h03); op(1, 16'h0092, 8'h02);     // R2 back to back
    op(0, 16'h0092, 8'h00);
    op(1, 16'h0800, 8'h00); op(0, 16'h0800, 8'h00);     // R3
    op(0, 16'h0810, 8'h00); op(1, 16'h0810, 8'hFF);     // R4, R6
    idle_check("R6");
    op(1, 16'h0812, 8'h00); op(0, 16'h0812, 8'h00);     // R6, R9
    op(1, 16'h0814, 8'h55); op(0, 16'h0814, 8'h00);     // R9
    op(1, 16'h081C, 8'hFA); op(0, 16'h081C, 8'h00);     // R7
    op(1, 16'h0850, 8'hFF); op(0, 16'h0850, 8'h00);     // R8
    op(1, 16'h0808, 8'h01); op(0, 16'h0808, 8'h00);     // R5
    op(1, 16'h080C, 8'hFF); op(1, 16'h0851, 8'h01);     // R12
    op(0, 16'h0852, 8'h00); op(1, 16'h039A, 8'h11);     // R11

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int cat = $urandom % 4;
      if (cat == 0)      a = PORTS[$urandom % 20];
      else if (cat == 1) a = 16'h0800 + 16'($urandom % 'h52);
      else if (cat == 2) a = 16'($urandom);
      else               a = 16'h0398 + 16'($urandom % 2);
      op(($urandom % 2) == 1, a, 8'($urandom));
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    idle_check("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule